// File: doc/BRIEF.md
# Complex Scrambling Pilot Generator

This block overlays a complex pilot scrambling sequence on a stream of complex baseband samples. Two 18-bit linear feedback shift registers run side by side; exclusive-OR combinations of their bits give one in-phase scrambling bit and one quadrature scrambling bit per chip. A fixed four-entry complex table maps that bit pair to plus or minus a programmable signed gain on each rail. The scaled pilot is added to the incoming I and Q samples, and the sum is clipped to 16 bits and registered.

A load pulse restarts the sequence. The upper register takes an 18-bit seed chosen from the primary scrambling code, and the lower register restarts from all ones. The registers advance one step per cycle in which the chip enable is high. An external negate input flips the sign of the gain, so that a sign pattern computed elsewhere can be applied. A gain of zero makes the block a plain one-cycle pipeline stage for the data.

Top module: `pilot_insert`

## Requirements
- R1: While `rstN` is low, `sumI` and `sumQ` are 0. Reset sets the upper register to 18'h00001 and the lower register to all ones.
- R2: A cycle with `seedLoad` high loads `seedVal` into the upper register and all ones into the lower register. This happens even when `chipEn` is high in the same cycle.
- R3: When `seedLoad` and `chipEn` are both low, both registers hold their value.
- R4: When `chipEn` is high and `seedLoad` is low, the upper register U steps by U <= {U[0]^U[7], U[17:1]}. This is the polynomial x^18+x^7+1.
- R5: On the same step, the lower register L steps by L <= {L[0]^L[5]^L[7]^L[10], L[17:1]}. The scrambling bits come from the current state: Ib = U[0]^L[0] and Qb = U[4]^U[6]^U[15]^L[5]^L[6]^L[8].
- R6: With gain g, the pilot (pilotI, pilotQ) for the bit pair {Ib,Qb} is: 00 gives (-g,+g), 01 gives (+g,+g), 10 gives (-g,-g), 11 gives (+g,-g).
- R7: When `gainWord` is 0, `sumI`/`sumQ` equal the previous cycle's `dataI`/`dataQ`.
- R8: When `negGain` is high, g = -gainWord, otherwise g = gainWord. The value +32768 is reachable.
- R9: The sum data + pilot on each rail saturates to the range -32768..32767 and never wraps.
- R10: Each output is registered. It reflects the inputs and register state of the cycle before the rising edge that updates it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| seedLoad | input | 1 | Restart the sequence from `seedVal` and all ones |
| seedVal | input | 18 | Start value for the upper register |
| gainWord | input | 16 | Signed pilot gain |
| negGain | input | 1 | Invert the sign of the gain |
| chipEn | input | 1 | Advance both registers by one chip |
| dataI | input | 16 | Signed in-phase input sample |
| dataQ | input | 16 | Signed quadrature input sample |
| sumI | output | 16 | Saturated in-phase sum |
| sumQ | output | 16 | Saturated quadrature sum |

## Verification
The bound checker compares the outputs with the previous cycle's inputs on every cycle. It checks that reset clears the outputs and that a zero gain passes the data through unchanged. It checks that no sum moves further from its input than the gain magnitude, so a wrap cannot slip by. Where there is headroom, it checks that the sum moves by exactly that magnitude. The actual sequence cannot be seen from a single cycle. That covers the register recurrences, the tap choice, the table's sign pattern, load priority over shift and the hold with the enable low. Only the bench's behavioural reference model can show these, by tracking both registers through seeds, enable gaps, negate patterns and saturating inputs.

// File: rtl/pilot_pkg.sv
package pilot_pkg;
  localparam int SREG_W = 18;
  localparam int SAMP_W = 16;
  localparam int RAILS  = 2;

  typedef struct packed {
    logic load;
    logic shift;
  } strobe_t;
endpackage

// File: rtl/pilot_ctrl.sv
module pilot_ctrl (
  input  logic              seedLoad,
  input  logic              chipEn,
  output pilot_pkg::strobe_t stb
);
  // A load wins over a shift in the same cycle.
  always_comb begin
    stb.load  = seedLoad;
    stb.shift = chipEn & ~seedLoad;
  end
endmodule

// File: rtl/pilot_lfsr.sv
module pilot_lfsr #(
  parameter int           W        = 18,
  parameter logic [W-1:0] TAP_MASK = '0,
  parameter logic [W-1:0] RST_VAL  = '1
) (
  input  logic               clk,
  input  logic               rstN,
  input  pilot_pkg::strobe_t stb,
  input  logic [W-1:0]       loadVal,
  output logic [W-1:0]       state
);
  logic fbBit;
  assign fbBit = ^(state & TAP_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          state <= RST_VAL;
    else if (stb.load)  state <= loadVal;
    else if (stb.shift) state <= {fbBit, state[W-1:1]};
  end
endmodule

// File: rtl/pilot_datapath.sv
module pilot_datapath #(
  parameter int SREG_W = pilot_pkg::SREG_W,
  parameter int SAMP_W = pilot_pkg::SAMP_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  pilot_pkg::strobe_t       stb,
  input  logic [SREG_W-1:0]        seedVal,
  input  logic signed [SAMP_W-1:0] gainWord,
  input  logic                     negGain,
  input  logic signed [SAMP_W-1:0] dataI,
  input  logic signed [SAMP_W-1:0] dataQ,
  output logic signed [SAMP_W-1:0] sumI,
  output logic signed [SAMP_W-1:0] sumQ
);
  localparam int PIL_W = SAMP_W + 1;
  localparam int SUM_W = SAMP_W + 2;
  localparam logic [SREG_W-1:0] UP_FB_MASK = SREG_W'(18'h00081); // bits 0,7
  localparam logic [SREG_W-1:0] LO_FB_MASK = SREG_W'(18'h004A1); // bits 0,5,7,10
  localparam logic [SREG_W-1:0] UP_Q_MASK  = SREG_W'(18'h08050); // bits 4,6,15
  localparam logic [SREG_W-1:0] LO_Q_MASK  = SREG_W'(18'h00160); // bits 5,6,8
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((1 << (SAMP_W-1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SUM_W'(1 << (SAMP_W-1));

  logic [SREG_W-1:0] upState, loState;

  pilot_lfsr #(.W(SREG_W), .TAP_MASK(UP_FB_MASK), .RST_VAL(SREG_W'(1))) u_upper (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(seedVal), .state(upState)
  );

  pilot_lfsr #(.W(SREG_W), .TAP_MASK(LO_FB_MASK), .RST_VAL({SREG_W{1'b1}})) u_lower (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal({SREG_W{1'b1}}), .state(loState)
  );

  logic iBit, qBit;
  assign iBit = upState[0] ^ loState[0];
  assign qBit = (^(upState & UP_Q_MASK)) ^ (^(loState & LO_Q_MASK));

  logic signed [PIL_W-1:0] gExt, gEff, gOpp;
  assign gExt = {gainWord[SAMP_W-1], gainWord};
  assign gEff = negGain ? -gExt : gExt;
  assign gOpp = -gEff;

  logic signed [PIL_W-1:0]  pilotR [pilot_pkg::RAILS];
  logic signed [SAMP_W-1:0] dataR  [pilot_pkg::RAILS];
  logic signed [SAMP_W-1:0] sumR   [pilot_pkg::RAILS];

  // Complex map: I sign follows qBit, Q sign follows the inverse of iBit.
  always_comb begin
    unique case ({iBit, qBit})
      2'b00:   begin pilotR[0] = gOpp; pilotR[1] = gEff; end
      2'b01:   begin pilotR[0] = gEff; pilotR[1] = gEff; end
      2'b10:   begin pilotR[0] = gOpp; pilotR[1] = gOpp; end
      default: begin pilotR[0] = gEff; pilotR[1] = gOpp; end
    endcase
  end

  assign dataR[0] = dataI;
  assign dataR[1] = dataQ;

  for (genvar r = 0; r < pilot_pkg::RAILS; r++) begin : g_rail
    logic signed [SUM_W-1:0]  wide;
    logic signed [SAMP_W-1:0] clipped;

    assign wide = {{(SUM_W-SAMP_W){dataR[r][SAMP_W-1]}}, dataR[r]}
                + {{(SUM_W-PIL_W){pilotR[r][PIL_W-1]}}, pilotR[r]};

    always_comb begin
      if (wide > SAT_HI)      clipped = SAT_HI[SAMP_W-1:0];
      else if (wide < SAT_LO) clipped = SAT_LO[SAMP_W-1:0];
      else                    clipped = wide[SAMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sumR[r] <= '0;
      else       sumR[r] <= clipped;
    end
  end

  assign sumI = sumR[0];
  assign sumQ = sumR[1];
endmodule

// File: rtl/pilot_insert.sv
module pilot_insert #(
  parameter int SREG_W = pilot_pkg::SREG_W,
  parameter int SAMP_W = pilot_pkg::SAMP_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     seedLoad,
  input  logic [SREG_W-1:0]        seedVal,
  input  logic signed [SAMP_W-1:0] gainWord,
  input  logic                     negGain,
  input  logic                     chipEn,
  input  logic signed [SAMP_W-1:0] dataI,
  input  logic signed [SAMP_W-1:0] dataQ,
  output logic signed [SAMP_W-1:0] sumI,
  output logic signed [SAMP_W-1:0] sumQ
);
  pilot_pkg::strobe_t stb;

  pilot_ctrl u_ctrl (.seedLoad(seedLoad), .chipEn(chipEn), .stb(stb));

  pilot_datapath #(.SREG_W(SREG_W), .SAMP_W(SAMP_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .seedVal(seedVal),
    .gainWord(gainWord), .negGain(negGain),
    .dataI(dataI), .dataQ(dataQ), .sumI(sumI), .sumQ(sumQ)
  );
endmodule

// File: rtl/pilot_insert_checker.sv
module pilot_insert_checker #(
  parameter int SAMP_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic signed [SAMP_W-1:0] gainWord,
  input logic signed [SAMP_W-1:0] dataI,
  input logic signed [SAMP_W-1:0] dataQ,
  input logic signed [SAMP_W-1:0] sumI,
  input logic signed [SAMP_W-1:0] sumQ
);
  localparam int W = SAMP_W + 2;
  localparam logic signed [W-1:0] MAXV = W'((1 << (SAMP_W-1)) - 1);

  logic signed [SAMP_W-1:0] prevI, prevQ, prevG;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin prevI <= '0; prevQ <= '0; prevG <= '0; end
    else begin prevI <= dataI; prevQ <= dataQ; prevG <= gainWord; end
  end

  function automatic logic signed [W-1:0] absW(input logic signed [W-1:0] v);
    return (v < 0) ? -v : v;
  endfunction

  logic signed [W-1:0] absG, absDI, absDQ, absPI, absPQ;
  assign absG  = absW(W'(prevG));
  assign absDI = absW(W'(sumI) - W'(prevI));
  assign absDQ = absW(W'(sumQ) - W'(prevQ));
  assign absPI = absW(W'(prevI));
  assign absPQ = absW(W'(prevQ));

  p_reset_zero_r1: assert property (@(posedge clk)
    !rstN |=> (sumI == 0 && sumQ == 0));

  p_zero_gain_r7: assert property (@(posedge clk) disable iff (!rstN)
    (prevG == 0) |-> (sumI == prevI && sumQ == prevQ));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
    (absDI <= absG && absDQ <= absG));

  p_magnitude_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((absPI + absG <= MAXV) && (absPQ + absG <= MAXV)) |-> (absDI == absG && absDQ == absG));
endmodule

bind pilot_insert pilot_insert_checker #(.SAMP_W(SAMP_W)) u_chk (
  .clk(clk), .rstN(rstN), .gainWord(gainWord),
  .dataI(dataI), .dataQ(dataQ), .sumI(sumI), .sumQ(sumQ)
);

// File: tb/pilot_insert_bench.sv
module pilot_insert_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic seedLoad = 1'b0;
  logic [17:0] seedVal = '0;
  logic signed [15:0] gainWord = '0;
  logic negGain = 1'b0;
  logic chipEn = 1'b0;
  logic signed [15:0] dataI = '0, dataQ = '0;
  logic signed [15:0] sumI, sumQ;

  always #2 clk = ~clk; // 250 MHz

  pilot_insert u_pilot_insert (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .seedVal(seedVal),
    .gainWord(gainWord), .negGain(negGain), .chipEn(chipEn),
    .dataI(dataI), .dataQ(dataQ), .sumI(sumI), .sumQ(sumQ)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  int upBits[18], loBits[18];
  int expI = 0, expQ = 0;

  function automatic int clip(input int v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 18; k++) begin upBits[k] = (k == 0); loBits[k] = 1; end
    expI = 0; expQ = 0;
  endtask

  // Behavioural reference: bit lists, table lookup, integer arithmetic.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) modelReset();
    else begin
      int g, ib, qb, pI, pQ, fu, fl;
      g  = negGain ? -int'(gainWord) : int'(gainWord);
      ib = upBits[0] ^ loBits[0];
      qb = upBits[4] ^ upBits[6] ^ upBits[15] ^ loBits[5] ^ loBits[6] ^ loBits[8];
      case ({ib[0], qb[0]})
        2'b00: begin pI = -g; pQ =  g; end
        2'b01: begin pI =  g; pQ =  g; end
        2'b10: begin pI = -g; pQ = -g; end
        default: begin pI = g; pQ = -g; end
      endcase
      expI = clip(int'(dataI) + pI);
      expQ = clip(int'(dataQ) + pQ);
      if (seedLoad) begin
        for (int k = 0; k < 18; k++) begin upBits[k] = seedVal[k]; loBits[k] = 1; end
      end else if (chipEn) begin
        fu = upBits[0] ^ upBits[7];
        fl = loBits[0] ^ loBits[5] ^ loBits[7] ^ loBits[10];
        for (int k = 0; k < 17; k++) begin upBits[k] = upBits[k+1]; loBits[k] = loBits[k+1]; end
        upBits[17] = fu; loBits[17] = fl;
      end
    end
  end

  task automatic check(input string req);
    checks++;
    if (int'(sumI) != expI || int'(sumQ) != expQ) begin
      errors++;
      $display("FAIL %s: sumI=%0d sumQ=%0d expected %0d %0d", req, sumI, sumQ, expI, expQ);
    end
  endtask

  task automatic tick(input string req);
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic randData(input int span);
    dataI = 16'($signed($urandom_range(2*span)) - span);
    dataQ = 16'($signed($urandom_range(2*span)) - span);
  endtask

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset");
    rstN = 1'b1;

    // R7: zero gain passes data with one cycle latency (R10)
    for (int n = 0; n < 40; n++) begin
      randData(30000); chipEn = n[0];
      tick(n < 20 ? "R7 zero gain" : "R10 latency");
    end

    // R2, R4, R5, R6: seeded sequence with moderate gain
    seedVal = 18'h2A5C3; seedLoad = 1'b1; gainWord = 16'sd1200; chipEn = 1'b0;
    tick("R2 load");
    seedLoad = 1'b0; chipEn = 1'b1;
    for (int n = 0; n < 400; n++) begin
      randData(10000);
      tick(n < 200 ? "R4 upper step" : "R5 lower step and R6 map");
    end

    // R3: enable gaps
    for (int n = 0; n < 200; n++) begin
      chipEn = ($urandom_range(3) == 0); randData(10000);
      tick("R3 hold when idle");
    end

    // R2: load together with enable takes priority
    for (int n = 0; n < 10; n++) begin
      seedVal = 18'($urandom); seedLoad = 1'b1; chipEn = 1'b1;
      tick("R2 load priority");
      seedLoad = 1'b0;
      for (int m = 0; m < 30; m++) begin randData(5000); tick("R2 after load"); end
    end

    // R8: negate pattern
    gainWord = -16'sd777;
    for (int n = 0; n < 300; n++) begin
      negGain = ((n / 17) % 2) == 1; randData(8000);
      tick("R8 negate");
    end

    // R9: saturation at both ends, including +32768 gain
    gainWord = 16'sd32767; negGain = 1'b0;
    for (int n = 0; n < 100; n++) begin
      dataI = 16'sd32767; dataQ = -16'sd32768; tick("R9 saturate");
    end
    gainWord = -16'sd32768; negGain = 1'b1;
    for (int n = 0; n < 100; n++) begin
      dataI = n[0] ? -16'sd32768 : 16'sd32767; dataQ = -dataI - 16'sd1;
      tick("R9 saturate full scale");
    end
    gainWord = 16'sd0; negGain = 1'b0; dataI = 16'sd4; dataQ = -16'sd4;
    tick("R7 gain back to zero");

    // R1 again mid-run
    rstN = 1'b0;
    @(negedge clk);
    check("R1 reset mid-run");
    rstN = 1'b1;
    gainWord = 16'sd500; chipEn = 1'b1;
    for (int n = 0; n < 50; n++) begin randData(1000); tick("R1 reset state sequence"); end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule